// File: doc/BRIEF.md
# Two-Read One-Write Program Register File

This block stores fifteen general-purpose words, 64 bits each by default, for a processor datapath. Each of its three ports carries a 4-bit register identifier. Values 0x0 to 0xE pick a real register. Value 0xF is a reserved selector that means "no register": it never takes part in a write, and it returns a defined zero on a read.

Two read ports are purely combinational. Each read port returns the selected register in the same cycle that its identifier is presented. One write port stores data on the rising clock edge when its enable is high. A read that names the register being written in the same cycle returns the value held before the edge, so the new value is seen only in the next cycle.

A synchronous reset clears every register. Reset takes priority over any write presented in the same cycle. The file has no internal states; the only sequential behaviour is the per-register load, hold and clear.

Top module: `regfile_2r1w`

## Requirements
- R1: With `rst` high at a rising edge, every register reads as zero after that edge, even if a write is presented in the same cycle.
- R2: With `wr_en` high and `wr_id` in 0x0..0xE at a rising edge, the addressed register holds `wr_data` after that edge.
- R3: A write with `wr_id` equal to 0xF leaves all fifteen registers unchanged.
- R4: With `wr_en` low, no register changes, whatever `wr_id` and `wr_data` carry.
- R5: A read port whose identifier is 0xF outputs all zeros.
- R6: Read ports are combinational: a change of `ra_id` or `rb_id` is reflected on the data output within the same cycle, with no clock edge in between.
- R7: When a read names the register being written in the same cycle, the read returns the old value before the edge and the new value after it.
- R8: Both read ports are independent: any two identifiers, including the same one, can be read at once, each with the correct value.
- R9: A write changes only the register it addresses; all other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous reset, active high, clears all registers |
| wr_en | input | 1 | Write enable |
| wr_id | input | 4 | Destination identifier; 0xF suppresses the write |
| wr_data | input | 64 | Data to store |
| ra_id | input | 4 | Identifier for read port A; 0xF reads zero |
| ra_data | output | 64 | Read port A data |
| rb_id | input | 4 | Identifier for read port B; 0xF reads zero |
| rb_data | output | 64 | Read port B data |

## Verification
The hardest case to reach is a read and a write of the same register in one cycle, because the check must be taken between the write being presented and the edge that commits it. The bench sets the write and the matching read identifier together just after a falling edge. It samples the read data before the next rising edge and expects the old value. It then samples again after the edge and expects the new value. Writes to the 0xF selector are checked by reading back all fifteen registers afterwards against a bench-held copy.

// File: rtl/rf_pkg.sv
package rf_pkg;
    parameter int RF_NREG  = 15;
    parameter int RF_WIDTH = 64;
    parameter int RF_IDW   = 4;
    parameter logic [RF_IDW-1:0] RF_NONE_ID = '1;
endpackage

// File: rtl/rf_wdec.sv
module rf_wdec #(
    parameter int NREG = rf_pkg::RF_NREG,
    parameter int IDW  = rf_pkg::RF_IDW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [IDW-1:0]  wr_id,
    output logic [NREG-1:0] sel
);
    genvar gi;
    generate
        for (gi = 0; gi < NREG; gi++) begin : g_sel
            assign sel[gi] = wr_en && (wr_id == IDW'(gi));
        end
    endgenerate

    // R9: at most one register is loaded per edge
    p_single_target_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));
endmodule

// File: rtl/rf_cell.sv
module rf_cell #(
    parameter int W = rf_pkg::RF_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= d;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (q == '0));

    p_hold_when_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));
endmodule

// File: rtl/rf_rdmux.sv
module rf_rdmux #(
    parameter int NREG = rf_pkg::RF_NREG,
    parameter int W    = rf_pkg::RF_WIDTH,
    parameter int IDW  = rf_pkg::RF_IDW
) (
    input  logic [NREG-1:0][W-1:0] regs,
    input  logic [IDW-1:0]         id,
    output logic [W-1:0]           data
);
    always_comb begin
        data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (id == IDW'(i)) begin
                data = regs[i];
            end
        end
    end
endmodule

// File: rtl/regfile_2r1w.sv
module regfile_2r1w #(
    parameter int NREG = rf_pkg::RF_NREG,
    parameter int W    = rf_pkg::RF_WIDTH,
    parameter int IDW  = rf_pkg::RF_IDW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [IDW-1:0] wr_id,
    input  logic [W-1:0]   wr_data,
    input  logic [IDW-1:0] ra_id,
    output logic [W-1:0]   ra_data,
    input  logic [IDW-1:0] rb_id,
    output logic [W-1:0]   rb_data
);
    localparam logic [IDW-1:0] NONE_ID = '1;

    logic [NREG-1:0]        sel;
    logic [NREG-1:0][W-1:0] bank;

    rf_wdec #(.NREG(NREG), .IDW(IDW)) u_wdec (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .wr_id (wr_id),
        .sel   (sel)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NREG; gi++) begin : g_cell
            rf_cell #(.W(W)) u_cell (
                .clk (clk),
                .rst (rst),
                .we  (sel[gi]),
                .d   (wr_data),
                .q   (bank[gi])
            );

            // R2: a selected register holds the presented data after the edge
            p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
                sel[gi] |=> (bank[gi] == $past(wr_data)));
        end
    endgenerate

    rf_rdmux #(.NREG(NREG), .W(W), .IDW(IDW)) u_rda (
        .regs (bank),
        .id   (ra_id),
        .data (ra_data)
    );

    rf_rdmux #(.NREG(NREG), .W(W), .IDW(IDW)) u_rdb (
        .regs (bank),
        .id   (rb_id),
        .data (rb_data)
    );

    p_none_write_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_id == NONE_ID)) |=> $stable(bank));

    p_none_read_a_r5: assert property (@(posedge clk) disable iff (rst)
        (ra_id == NONE_ID) |-> (ra_data == '0));

    p_none_read_b_r5: assert property (@(posedge clk) disable iff (rst)
        (rb_id == NONE_ID) |-> (rb_data == '0));

    // R8: two ports naming the same register agree
    p_ports_agree_r8: assert property (@(posedge clk) disable iff (rst)
        (ra_id == rb_id) |-> (ra_data == rb_data));
endmodule

// File: tb/sim_regfile_2r1w.sv
module sim_regfile_2r1w;
    localparam int NREG = 15;
    localparam int W    = 64;

    logic         clk = 1'b0;
    logic         rst;
    logic         wr_en;
    logic [3:0]   wr_id;
    logic [W-1:0] wr_data;
    logic [3:0]   ra_id;
    logic [W-1:0] ra_data;
    logic [3:0]   rb_id;
    logic [W-1:0] rb_data;

    logic [W-1:0] model [NREG];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    regfile_2r1w u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_id(wr_id), .wr_data(wr_data),
        .ra_id(ra_id), .ra_data(ra_data), .rb_id(rb_id), .rb_data(rb_data)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic en, input logic [3:0] id, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = en; wr_id = id; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        if (en && id != 4'hF) model[id] = d;
    endtask

    task automatic verify_all(input string req);
        @(negedge clk);
        for (int i = 0; i < NREG; i++) begin
            ra_id = 4'(i); rb_id = 4'(NREG - 1 - i);
            #1;
            check(req, ra_data, model[i]);
            check(req, rb_data, model[NREG - 1 - i]);
        end
    endtask

    task automatic t_reset_r1;
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b1; wr_id = 4'h3; wr_data = 64'hDEAD_BEEF_0000_0003;
        @(posedge clk); #1;
        rst = 1'b0; wr_en = 1'b0;
        for (int i = 0; i < NREG; i++) model[i] = '0;
        verify_all("R1");
    endtask

    task automatic t_fill_r2;
        for (int i = 0; i < NREG; i++)
            do_write(1'b1, 4'(i), {32'hA5A5_0000 + 32'(i), ~(32'h1111_1111 * 32'(i))});
        verify_all("R2");
    endtask

    task automatic t_none_write_r3;
        do_write(1'b1, 4'hF, 64'hFFFF_0000_FFFF_0000);
        verify_all("R3");
    endtask

    task automatic t_disabled_r4;
        for (int i = 0; i < 4; i++) do_write(1'b0, 4'(i * 3), 64'h0BAD_0BAD_0000_0000 + 64'(i));
        verify_all("R4");
    endtask

    task automatic t_none_read_r5;
        @(negedge clk);
        ra_id = 4'hF; rb_id = 4'hF; #1;
        check("R5", ra_data, '0);
        check("R5", rb_data, '0);
    endtask

    task automatic t_comb_read_r6;
        @(negedge clk);
        ra_id = 4'h2; #1;
        check("R6", ra_data, model[2]);
        ra_id = 4'hE; #1;
        check("R6", ra_data, model[14]);
    endtask

    task automatic t_same_cycle_r7;
        logic [W-1:0] old_v;
        old_v = model[5];
        @(negedge clk);
        wr_en = 1'b1; wr_id = 4'h5; wr_data = 64'h7777_5555_3333_1111;
        ra_id = 4'h5; rb_id = 4'h5; #1;
        check("R7", ra_data, old_v);
        check("R7", rb_data, old_v);
        @(posedge clk); #1;
        wr_en = 1'b0; model[5] = 64'h7777_5555_3333_1111;
        check("R7", ra_data, model[5]);
        check("R7", rb_data, model[5]);
    endtask

    task automatic t_ports_r8;
        @(negedge clk);
        ra_id = 4'h0; rb_id = 4'hE; #1;
        check("R8", ra_data, model[0]);
        check("R8", rb_data, model[14]);
        rb_id = 4'h0; #1;
        check("R8", rb_data, model[0]);
    endtask

    task automatic t_isolation_r9;
        do_write(1'b1, 4'h7, '1);
        do_write(1'b1, 4'h0, 64'h0123_4567_89AB_CDEF);
        verify_all("R9");
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_id = '0; wr_data = '0; ra_id = '0; rb_id = '0;
        repeat (2) @(posedge clk);
        t_reset_r1;
        t_fill_r2;
        t_none_write_r3;
        t_disabled_r4;
        t_none_read_r5;
        t_comb_read_r6;
        t_same_cycle_r7;
        t_ports_r8;
        t_isolation_r9;
        t_reset_r1;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule